// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting channel for an interval timer. A CPU-side command port selects one of six operating modes and binary or decimal (BCD) counting, a separate load port supplies the start value, and a gate input either enables counting or triggers it, depending on the mode. The channel drives one output whose waveform depends on the mode: a level change at terminal count, a one-shot pulse, a periodic low pulse, a square wave, or a one-tick strobe.

The count advances only on cycles where `cnt_tick` is high, so the channel counts an external rate reduced to the system clock. `gate` is synchronous to `clk`, and a rising edge is seen when `gate` is high in a cycle after a cycle where it was low. The command, load and read strobes are plain single-cycle pulses. They are accepted in any cycle and apply no back-pressure, so the block has no valid/ready handshake. When a command and a load arrive in the same cycle, the command wins. The current count can be read at any time. A latch command freezes a copy for a stable read while the counter keeps running.

Top module: `ictr_channel`

## Requirements
- R1: After reset the output is low, `rd_data` reads 0, and no counting happens until a mode and a count are written.
- R2: Command word fields: bit 0 selects BCD (1) or binary (0), bits 3..1 hold the mode number, and bit 4 set makes it a latch command that leaves the mode unchanged. Mode numbers 6 and 7 act as modes 2 and 3. A mode write drives the output low for mode 0 and high for every other mode, and halts counting until a new count is loaded.
- R3: Mode 0: a load of N keeps the output low and starts counting. The output rises N ticks after the load and stays high until the next load. Gate low freezes the count.
- R4: Mode 1: a load alone starts nothing. A rising gate edge loads N and drives the output low, and the output rises N ticks later. Gate low during the count has no effect. A new rising edge restarts the count at N.
- R5: Mode 2: with gate high the output repeats a period of N ticks, low for exactly one tick, and the count reloads itself.
- R6: Mode 3: the output repeats a period of N ticks, high for ceil(N/2) and low for floor(N/2).
- R7: Modes 2 and 3: gate low forces the output high on the next cycle and freezes the count. The next rising gate edge reloads N and restarts with the output high.
- R8: Mode 4: N ticks after the load the output goes low for exactly one tick, then high. Only one strobe occurs per load.
- R9: Mode 5: a load alone starts nothing. A rising gate edge loads N, and N ticks later the output gives a one-tick low strobe.
- R10: In BCD mode the count steps down in decimal digits (0100 to 0099). A start value of 0 stands for 10000 in BCD and 65536 in binary, so the first tick goes to 9999 or FFFF.
- R11: A latch command copies the count. `rd_data` then returns that copy, unchanged by counting and by further latch commands, until one `rd_req`. After that read, `rd_data` shows the live count, which kept running.
- R12: The count and the output advance only in cycles with `cnt_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count enable; one count step per high cycle |
| gate | input | 1 | Gate: level enable or rising-edge trigger, by mode |
| ctl_wr | input | 1 | Command word strobe |
| ctl_word | input | 5 | Command word (BCD, mode, latch fields) |
| ld_wr | input | 1 | Count load strobe |
| ld_val | input | 16 | Start value (0 means full range) |
| rd_req | input | 1 | Read strobe; releases a latched copy |
| rd_data | output | 16 | Latched copy if one is held, else the live count |
| cnt_out | output | 1 | Channel output waveform |

## Verification
The periodic modes are driven by a table of start values: even and odd values, small values near the minimum, BCD values, and the aliased mode numbers 6 and 7. For each entry the bench measures the steady low and high widths. Odd values separate a correct mode-3 split from a naive half, and the BCD entries reveal a binary borrow. Directed sequences cover the other modes: gate pauses and triggers placed mid-count show whether the gate is read as a level or as an edge, and retriggers show a restart. The full-range zero load, latch-and-hold reads and sparse ticks show the wrap value, that the held copy does not move, and the count enable.

// File: rtl/ictr_pkg.sv
package ictr_pkg;
  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } ictr_mode_e;

  localparam int CW_W        = 5;
  localparam int CW_BCD_BIT  = 0;
  localparam int CW_LATCH_BIT = 4;

  // mode numbers 6 and 7 fold onto 2 and 3
  function automatic ictr_mode_e norm_mode(input logic [2:0] f);
    if (f[1]) return ictr_mode_e'({1'b0, f[1:0]});
    return ictr_mode_e'(f);
  endfunction
endpackage

// File: rtl/ictr_dec.sv
module ictr_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  output logic [W-1:0] res
);
  localparam int ND = W / 4;

  logic [ND-1:0] brw;
  logic [W-1:0]  bcd_res;

  assign brw[0] = 1'b1;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [3:0] d;
    assign d = val[4*i +: 4];
    assign bcd_res[4*i +: 4] = !brw[i] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    if (i < ND - 1) begin : g_brw
      assign brw[i+1] = brw[i] & (d == 4'd0);
    end
  end

  assign res = bcd ? bcd_res : (val - W'(1));
endmodule

// File: rtl/ictr_gate.sv
module ictr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign rise = gate & ~gate_q;
endmodule

// File: rtl/ictr_rdhold.sv
module ictr_rdhold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         latch_cmd,
  input  logic         rd_req,
  input  logic [W-1:0] live,
  output logic [W-1:0] rd_data
);
  logic         held_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      hold_q <= '0;
    end else if (rd_req) begin
      held_q <= 1'b0;
    end else if (latch_cmd && !held_q) begin
      held_q <= 1'b1;
      hold_q <= live;
    end
  end

  assign rd_data = held_q ? hold_q : live;

  a_r11_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !rd_req) |=> (held_q && $stable(hold_q)));
endmodule

// File: rtl/ictr_channel.sv
module ictr_channel
  import ictr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_tick,
  input  logic            gate,
  input  logic            ctl_wr,
  input  logic [CW_W-1:0] ctl_word,
  input  logic            ld_wr,
  input  logic [W-1:0]    ld_val,
  input  logic            rd_req,
  output logic [W-1:0]    rd_data,
  output logic            cnt_out
);
  ictr_mode_e   mode_q, new_mode;
  logic         bcd_q, run_q, armed_q, have_q, out_q;
  logic [W-1:0] count_q, reload_q, dec1, dec2, even_reload;
  logic         mode_wr, latch_cmd, gate_rise, trig, gated_mode, at_one, at_two;

  assign new_mode    = norm_mode(ctl_word[3:1]);
  assign mode_wr     = ctl_wr && !ctl_word[CW_LATCH_BIT];
  assign latch_cmd   = ctl_wr &&  ctl_word[CW_LATCH_BIT];
  assign gated_mode  = (mode_q == M_RATE) || (mode_q == M_SQUARE);
  assign trig        = gate_rise && have_q &&
                       (gated_mode || mode_q == M_ONESHOT || mode_q == M_HWSTROBE);
  assign at_one      = (count_q == W'(1));
  assign at_two      = (count_q == W'(2));
  assign even_reload = {reload_q[W-1:1], 1'b0};

  ictr_gate u_gate (.clk(clk), .rst_n(rst_n), .gate(gate), .rise(gate_rise));

  ictr_dec #(.W(W)) u_dec1 (.val(count_q), .bcd(bcd_q), .res(dec1));
  ictr_dec #(.W(W)) u_dec2 (.val(dec1),    .bcd(bcd_q), .res(dec2));

  ictr_rdhold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .latch_cmd(latch_cmd), .rd_req(rd_req),
    .live(count_q), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_TERM;
      bcd_q    <= 1'b0;
      run_q    <= 1'b0;
      armed_q  <= 1'b0;
      have_q   <= 1'b0;
      out_q    <= 1'b0;
      count_q  <= '0;
      reload_q <= '0;
    end else if (mode_wr) begin
      mode_q  <= new_mode;
      bcd_q   <= ctl_word[CW_BCD_BIT];
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      have_q  <= 1'b0;
      out_q   <= (new_mode != M_TERM);
    end else if (ld_wr) begin
      reload_q <= ld_val;
      have_q   <= 1'b1;
      case (mode_q)
        M_TERM: begin
          count_q <= ld_val; out_q <= 1'b0; run_q <= 1'b1; armed_q <= 1'b1;
        end
        M_RATE, M_SQUARE: begin
          count_q <= ld_val; out_q <= 1'b1; run_q <= 1'b1;
        end
        M_SWSTROBE: begin
          count_q <= ld_val; out_q <= 1'b1; run_q <= 1'b1; armed_q <= 1'b1;
        end
        default: ; // triggered modes wait for the gate
      endcase
    end else if (trig) begin
      count_q <= reload_q;
      run_q   <= 1'b1;
      armed_q <= 1'b1;
      out_q   <= (mode_q != M_ONESHOT);
    end else if (gated_mode && !gate) begin
      out_q <= 1'b1;
    end else if (run_q && cnt_tick) begin
      case (mode_q)
        M_TERM: if (gate) begin
          count_q <= dec1;
          if (armed_q && at_one) begin out_q <= 1'b1; armed_q <= 1'b0; end
        end
        M_ONESHOT: begin
          count_q <= dec1;
          if (armed_q && at_one) begin out_q <= 1'b1; armed_q <= 1'b0; end
        end
        M_RATE: begin
          if (at_one) begin
            count_q <= reload_q; out_q <= 1'b1;
          end else begin
            count_q <= dec1;
            if (at_two) out_q <= 1'b0;
          end
        end
        M_SQUARE: begin
          if (at_two) begin
            out_q   <= !out_q;
            count_q <= out_q ? even_reload : reload_q;
          end else begin
            count_q <= count_q[0] ? dec1 : dec2;
          end
        end
        M_SWSTROBE, M_HWSTROBE: begin
          if (!out_q) out_q <= 1'b1;
          if (gate || mode_q == M_HWSTROBE) begin
            count_q <= dec1;
            if (armed_q && at_one) begin out_q <= 1'b0; armed_q <= 1'b0; end
          end
        end
        default: ;
      endcase
    end
  end

  assign cnt_out = out_q;

  a_r2_mode0_out_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && ctl_word[3:1] == 3'd0) |=> !cnt_out);

  a_r3_term_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TERM && out_q && !mode_wr && !ld_wr) |=> cnt_out);

  a_r4_trigger_drops_out: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ONESHOT && have_q && gate_rise && !mode_wr && !ld_wr)
      |=> (!cnt_out && count_q == reload_q));

  a_r7_gate_low_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_mode && !gate && !mode_wr && !ld_wr) |=> cnt_out);

  a_r8_strobe_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_SWSTROBE || mode_q == M_HWSTROBE) && !out_q && run_q && cnt_tick
      && !mode_wr && !ld_wr && !trig) |=> cnt_out);

  a_r12_no_tick_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !mode_wr && !ld_wr && !trig) |=> $stable(count_q));
endmodule

// File: tb/tb_ictr_channel.sv
`timescale 1ns/1ps
module tb_ictr_channel;
  logic        clk = 1'b0;
  logic        rst_n, cnt_tick, gate, ctl_wr, ld_wr, rd_req;
  logic [4:0]  ctl_word;
  logic [15:0] ld_val, rd_data;
  logic        cnt_out;
  int          nchk = 0;
  int          nerr = 0;

  always #2 clk = ~clk;

  ictr_channel dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .gate(gate),
    .ctl_wr(ctl_wr), .ctl_word(ctl_word), .ld_wr(ld_wr), .ld_val(ld_val),
    .rd_req(rd_req), .rd_data(rd_data), .cnt_out(cnt_out)
  );

  // {command word, start value, expected low width, expected high width}
  localparam logic [52:0] VEC [0:9] = '{
    {5'h04, 16'd4,     16'd1, 16'd3},
    {5'h04, 16'd7,     16'd1, 16'd6},
    {5'h06, 16'd4,     16'd2, 16'd2},
    {5'h06, 16'd5,     16'd2, 16'd3},
    {5'h06, 16'd6,     16'd3, 16'd3},
    {5'h06, 16'd3,     16'd1, 16'd2},
    {5'h07, 16'h0010,  16'd5, 16'd5},
    {5'h05, 16'h0012,  16'd1, 16'd11},
    {5'h0C, 16'd5,     16'd1, 16'd4},
    {5'h0E, 16'd7,     16'd3, 16'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [4:0] w);
    ctl_word = w; ctl_wr = 1'b1; step(1); ctl_wr = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    ld_val = v; ld_wr = 1'b1; step(1); ld_wr = 1'b0;
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (cnt_out === lvl && n < 2000) begin step(1); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int lo, hi, dummy, lows;
    rst_n = 1'b0; cnt_tick = 1'b1; gate = 1'b0; ctl_wr = 1'b0; ld_wr = 1'b0;
    rd_req = 1'b0; ctl_word = '0; ld_val = '0;
    step(3); rst_n = 1'b1; step(1);
    chk("R1 out after reset", cnt_out, 0);
    chk("R1 count after reset", rd_data, 0);
    step(5);
    chk("R1 no counting", rd_data, 0);

    // table walk: periodic modes (R5, R6, R2 aliasing)
    gate = 1'b1;
    for (int i = 0; i < 10; i++) begin
      set_mode(VEC[i][52:48]);
      load(VEC[i][47:32]);
      run_len(1'b1, dummy);
      run_len(1'b0, lo);
      run_len(1'b1, hi);
      chk($sformatf("R5/R6 vec%0d low width", i), lo, VEC[i][31:16]);
      chk($sformatf("R5/R6 vec%0d high width", i), hi, VEC[i][15:0]);
    end

    // R2 mode write output level
    set_mode(5'h02); chk("R2 mode1 out high", cnt_out, 1);
    set_mode(5'h00); chk("R2 mode0 out low", cnt_out, 0);

    // R3 mode 0
    load(16'd5);
    chk("R3 out low after load", cnt_out, 0);
    chk("R3 count loaded", rd_data, 5);
    step(4); chk("R3 out low before end", cnt_out, 0); chk("R3 count 1", rd_data, 1);
    step(1); chk("R3 out high at end", cnt_out, 1);
    step(3); chk("R3 out stays high", cnt_out, 1);
    load(16'd5); step(2); chk("R3 count before pause", rd_data, 3);
    gate = 1'b0; step(4);
    chk("R3 gate low freezes", rd_data, 3); chk("R3 out low in pause", cnt_out, 0);
    gate = 1'b1; step(2); chk("R3 resumed out low", cnt_out, 0);
    step(1); chk("R3 resumed end", cnt_out, 1);

    // R4 mode 1
    gate = 1'b0; set_mode(5'h02); load(16'd4); step(3);
    chk("R4 load alone no start", cnt_out, 1);
    gate = 1'b1; step(1);
    chk("R4 trigger out low", cnt_out, 0); chk("R4 trigger loads", rd_data, 4);
    step(3); chk("R4 still low", cnt_out, 0);
    step(1); chk("R4 ends high", cnt_out, 1);
    gate = 1'b0; step(1); gate = 1'b1; step(1); step(1);
    gate = 1'b0; step(1);
    chk("R4 gate low no effect", rd_data, 2); chk("R4 out low gate low", cnt_out, 0);
    gate = 1'b1; step(1);
    chk("R4 retrigger reload", rd_data, 4); chk("R4 retrigger out", cnt_out, 0);
    step(3); chk("R4 retrigger low", cnt_out, 0);
    step(1); chk("R4 retrigger end", cnt_out, 1);

    // R7 gate in mode 2
    gate = 1'b1; set_mode(5'h04); load(16'd4); step(3);
    chk("R7 pulse low", cnt_out, 0);
    gate = 1'b0; step(1); chk("R7 forced high", cnt_out, 1);
    step(3); chk("R7 frozen count", rd_data, 1);
    gate = 1'b1; step(1);
    chk("R7 restart reload", rd_data, 4); chk("R7 restart high", cnt_out, 1);
    step(2); chk("R7 high before pulse", cnt_out, 1);
    step(1); chk("R7 pulse after restart", cnt_out, 0);

    // R8 mode 4
    set_mode(5'h08); chk("R8 out high after mode", cnt_out, 1);
    load(16'd3); step(2); chk("R8 high before strobe", cnt_out, 1);
    step(1); chk("R8 strobe low", cnt_out, 0);
    step(1); chk("R8 strobe one tick", cnt_out, 1);
    lows = 0;
    for (int k = 0; k < 20; k++) begin step(1); if (cnt_out !== 1'b1) lows++; end
    chk("R8 single strobe", lows, 0);

    // R9 mode 5
    gate = 1'b0; set_mode(5'h0A); load(16'd3); step(5);
    chk("R9 load alone no strobe", cnt_out, 1);
    gate = 1'b1; step(1);
    chk("R9 trigger loads", rd_data, 3); chk("R9 out high", cnt_out, 1);
    step(2); chk("R9 high before strobe", cnt_out, 1);
    step(1); chk("R9 strobe", cnt_out, 0);
    step(1); chk("R9 strobe ends", cnt_out, 1);

    // R10 BCD and full range
    set_mode(5'h01); load(16'h0100); step(1);
    chk("R10 bcd borrow", rd_data, 16'h0099);
    load(16'h0000); step(1); chk("R10 bcd zero wraps", rd_data, 16'h9999);
    step(9998); chk("R10 bcd 10000 not yet", cnt_out, 0);
    step(1); chk("R10 bcd 10000 end", cnt_out, 1);
    set_mode(5'h00); load(16'h0100); step(1);
    chk("R10 binary borrow", rd_data, 16'h00FF);
    load(16'h0000); step(1); chk("R10 binary zero wraps", rd_data, 16'hFFFF);

    // R11 latch
    load(16'd100); step(10); chk("R11 live count", rd_data, 90);
    ctl_word = 5'h10; ctl_wr = 1'b1; step(1); ctl_wr = 1'b0;
    chk("R11 latched copy", rd_data, 90); chk("R11 mode kept", cnt_out, 0);
    step(5); chk("R11 copy holds", rd_data, 90);
    ctl_word = 5'h10; ctl_wr = 1'b1; step(1); ctl_wr = 1'b0;
    chk("R11 second latch ignored", rd_data, 90);
    rd_req = 1'b1; step(1); rd_req = 1'b0;
    chk("R11 live after read", rd_data, 82);

    // R12 tick enable
    load(16'd3); cnt_tick = 1'b0; step(10);
    chk("R12 no tick count", rd_data, 3); chk("R12 no tick out", cnt_out, 0);
    for (int k = 0; k < 2; k++) begin cnt_tick = 1'b1; step(1); cnt_tick = 1'b0; step(1); end
    chk("R12 two ticks", rd_data, 1); chk("R12 out low", cnt_out, 0);
    cnt_tick = 1'b1; step(1); cnt_tick = 1'b0; step(1);
    chk("R12 third tick ends", cnt_out, 1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule